// File: doc/BRIEF.md
# Detection-Driven Gate Delay Sequencer

This block opens a detector enable gate a programmable number of clock cycles after a laser synchronization pulse. It keeps only the first detection that arrives while the gate is open. That detection closes the gate at once, so every event it accepts comes from a detector that was freshly re-enabled and had no dead-time left from an earlier event.

After each accepted detection the gate delay moves forward by a programmable step, so later runs probe later arrival times. The delay stays put on a run with no detection, which makes the sweep across the window driven by detections rather than by a fixed scan. When the next delay would pass the window end, the delay returns to the programmed start and a sweep-done pulse is issued. Each accepted detection is reported with a timestamp: the gate delay plus the cycles from gate opening to detection, which equals the cycles counted since the synchronization pulse.

Top module: `gate_sweep_seq`

## Requirements
- R1: While reset is held and in the first cycle after it, `gate_en_o`, `hit_vld_o` and `sweep_done_o` are low and `cur_dly_o` equals `start_dly_i`.
- R2: A `sync_i` pulse sampled with no run in progress starts a run. The clock cycle after that edge is position 0 and each later cycle adds one. `gate_en_o` is high from position `cur_dly_o` onward and stays high until the run ends.
- R3: A `det_i` sampled high while `gate_en_o` is high produces a one-cycle `hit_vld_o` in the next cycle, and the gate is low in that cycle. Detections sampled while the gate is low are ignored, and so are detections after the first in a run.
- R4: With `hit_vld_o`, `hit_ts_o` equals the position of the cycle in which the detection was sampled, that is, the gate delay plus the offset from gate opening.
- R5: After an accepted detection, `cur_dly_o` becomes the old delay plus `step_i` when that sum is not greater than `win_end_i`. The new value is visible in the `hit_vld_o` cycle.
- R6: When that sum is greater than `win_end_i`, `cur_dly_o` becomes `start_dly_i` and `sweep_done_o` is high for one cycle, together with `hit_vld_o`. A sum exactly equal to `win_end_i` does not wrap.
- R7: A run with no accepted detection ends after position `win_end_i`. The gate is low from the next cycle on, no `hit_vld_o` occurs and `cur_dly_o` is unchanged.
- R8: A `sync_i` pulse sampled while a run is in progress is ignored. The gate keeps the timing of the run already under way.
- R9: A detection sampled in position `win_end_i` is still accepted, with timestamp `win_end_i`.
- R10: With a delay of 0 the gate is high in position 0, and a detection there has timestamp 0.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| sync_i | input | 1 | Laser synchronization pulse |
| det_i | input | 1 | Detector event strobe |
| start_dly_i | input | DLY_W | Delay loaded at reset and on wrap |
| step_i | input | DLY_W | Delay increment per accepted detection |
| win_end_i | input | DLY_W | Last position of the window |
| gate_en_o | output | 1 | Detector enable gate |
| hit_vld_o | output | 1 | First-detection valid strobe |
| hit_ts_o | output | DLY_W | Timestamp of the accepted detection |
| cur_dly_o | output | DLY_W | Current gate delay |
| sweep_done_o | output | 1 | Delay wrapped back to the start |

## Verification
Two events can end a run in the same clock edge: a detection accepted in the last window position, and the window closing. The bench drives `det_i` in position `win_end_i` while the delay sits one step short of wrapping. The detection must win over the window close, so the bench expects a `hit_vld_o` with timestamp `win_end_i`, and in that same cycle a `sweep_done_o` together with the delay reloaded to the start. A second collision, a synchronization pulse during an open gate, is judged from the gate falling at the original window end.

// File: rtl/gss_pkg.sv
package gss_pkg;
   typedef enum logic [0:0] {
      PH_IDLE = 1'b0,
      PH_RUN  = 1'b1
   } phase_e;

   function automatic logic wrap_needed(input logic [32:0] sum, input logic [32:0] lim);
      return sum > lim;
   endfunction
endpackage

// File: rtl/gss_timer.sv
module gss_timer #(
   parameter int DLY_W = 10
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             clear_i,
   input  logic             adv_i,
   output logic [DLY_W-1:0] pos_o
);
   always_ff @(posedge clk) begin
      if (!rst_n) begin
         pos_o <= '0;
      end else if (clear_i) begin
         pos_o <= '0;
      end else if (adv_i) begin
         pos_o <= pos_o + 1'b1;
      end
   end
endmodule

// File: rtl/gss_gate_fsm.sv
module gss_gate_fsm #(
   parameter int DLY_W = 10
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             sync_i,
   input  logic             det_i,
   input  logic [DLY_W-1:0] pos_i,
   input  logic [DLY_W-1:0] cur_dly_i,
   input  logic [DLY_W-1:0] win_end_i,
   output logic             clear_o,
   output logic             adv_o,
   output logic             accept_o,
   output logic             gate_o,
   output logic             hit_vld_o,
   output logic [DLY_W-1:0] ts_o
);
   import gss_pkg::*;

   phase_e           phase_q;
   logic             end_hit;
   logic             end_win;
   logic [DLY_W-1:0] pos_nxt;

   always_comb begin
      clear_o  = (phase_q == PH_IDLE) && sync_i;
      end_hit  = (phase_q == PH_RUN) && gate_o && det_i;
      end_win  = (phase_q == PH_RUN) && (pos_i >= win_end_i);
      adv_o    = (phase_q == PH_RUN) && !end_hit && !end_win;
      accept_o = end_hit;
      pos_nxt  = pos_i + 1'b1;
   end

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         phase_q   <= PH_IDLE;
         gate_o    <= 1'b0;
         hit_vld_o <= 1'b0;
         ts_o      <= '0;
      end else begin
         hit_vld_o <= 1'b0;
         case (phase_q)
            PH_IDLE: begin
               if (sync_i) begin
                  phase_q <= PH_RUN;
                  gate_o  <= (cur_dly_i == '0);
               end
            end
            default: begin
               if (end_hit) begin
                  phase_q   <= PH_IDLE;
                  gate_o    <= 1'b0;
                  hit_vld_o <= 1'b1;
                  ts_o      <= pos_i;
               end else if (end_win) begin
                  phase_q <= PH_IDLE;
                  gate_o  <= 1'b0;
               end else if (pos_nxt == cur_dly_i) begin
                  gate_o <= 1'b1;
               end
            end
         endcase
      end
   end
endmodule

// File: rtl/gss_delay_step.sv
module gss_delay_step #(
   parameter int DLY_W = 10
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             accept_i,
   input  logic [DLY_W-1:0] start_dly_i,
   input  logic [DLY_W-1:0] step_i,
   input  logic [DLY_W-1:0] win_end_i,
   output logic [DLY_W-1:0] cur_dly_o,
   output logic             done_o
);
   import gss_pkg::*;

   localparam int SUM_W = DLY_W + 1;

   logic [SUM_W-1:0] sum;
   logic [32:0]      sum_x;
   logic [32:0]      lim_x;
   logic             wrap;

   always_comb begin
      sum   = {1'b0, cur_dly_o} + {1'b0, step_i};
      sum_x = 33'(sum);
      lim_x = 33'(win_end_i);
      wrap  = wrap_needed(sum_x, lim_x);
   end

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         cur_dly_o <= start_dly_i;
         done_o    <= 1'b0;
      end else begin
         done_o <= 1'b0;
         if (accept_i) begin
            if (wrap) begin
               cur_dly_o <= start_dly_i;
               done_o    <= 1'b1;
            end else begin
               cur_dly_o <= sum[DLY_W-1:0];
            end
         end
      end
   end
endmodule

// File: rtl/gate_sweep_seq.sv
module gate_sweep_seq #(
   parameter int DLY_W   = 10,
   parameter bit HOLD_TS = 1'b1
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             sync_i,
   input  logic             det_i,
   input  logic [DLY_W-1:0] start_dly_i,
   input  logic [DLY_W-1:0] step_i,
   input  logic [DLY_W-1:0] win_end_i,
   output logic             gate_en_o,
   output logic             hit_vld_o,
   output logic [DLY_W-1:0] hit_ts_o,
   output logic [DLY_W-1:0] cur_dly_o,
   output logic             sweep_done_o
);
   if (DLY_W < 2 || DLY_W > 32) begin : g_bad_width
      $error("gate_sweep_seq: DLY_W must lie in 2..32");
   end

   logic             clear;
   logic             adv;
   logic             accept;
   logic [DLY_W-1:0] pos;
   logic [DLY_W-1:0] ts_q;

   gss_timer #(.DLY_W(DLY_W)) u_timer (
      .clk     (clk),
      .rst_n   (rst_n),
      .clear_i (clear),
      .adv_i   (adv),
      .pos_o   (pos)
   );

   gss_gate_fsm #(.DLY_W(DLY_W)) u_fsm (
      .clk       (clk),
      .rst_n     (rst_n),
      .sync_i    (sync_i),
      .det_i     (det_i),
      .pos_i     (pos),
      .cur_dly_i (cur_dly_o),
      .win_end_i (win_end_i),
      .clear_o   (clear),
      .adv_o     (adv),
      .accept_o  (accept),
      .gate_o    (gate_en_o),
      .hit_vld_o (hit_vld_o),
      .ts_o      (ts_q)
   );

   gss_delay_step #(.DLY_W(DLY_W)) u_step (
      .clk         (clk),
      .rst_n       (rst_n),
      .accept_i    (accept),
      .start_dly_i (start_dly_i),
      .step_i      (step_i),
      .win_end_i   (win_end_i),
      .cur_dly_o   (cur_dly_o),
      .done_o      (sweep_done_o)
   );

   if (HOLD_TS) begin : g_ts_hold
      assign hit_ts_o = ts_q;
   end else begin : g_ts_mask
      assign hit_ts_o = hit_vld_o ? ts_q : '0;
   end
endmodule

// File: rtl/gss_checker.sv
module gss_checker #(
   parameter int DLY_W = 10
) (
   input logic             clk,
   input logic             rst_n,
   input logic             det_i,
   input logic [DLY_W-1:0] start_dly_i,
   input logic [DLY_W-1:0] win_end_i,
   input logic             gate_en_o,
   input logic             hit_vld_o,
   input logic [DLY_W-1:0] hit_ts_o,
   input logic [DLY_W-1:0] cur_dly_o,
   input logic             sweep_done_o
);
   // R3: an open gate that sees a detection yields a strobe next cycle
   assert_hit_follows_det_R3: assert property (@(posedge clk) disable iff (!rst_n)
      gate_en_o && det_i |=> hit_vld_o);

   // R3: the gate is closed whenever a hit is reported
   assert_gate_shut_on_hit_R3: assert property (@(posedge clk) disable iff (!rst_n)
      hit_vld_o |-> !gate_en_o);

   // R3: strobes never come back to back
   assert_single_strobe_R3: assert property (@(posedge clk) disable iff (!rst_n)
      hit_vld_o |=> !hit_vld_o);

   // R4: timestamp lies between the gate delay and the window end
   assert_ts_in_window_R4: assert property (@(posedge clk) disable iff (!rst_n)
      hit_vld_o |-> (hit_ts_o >= $past(cur_dly_o)) && (hit_ts_o <= $past(win_end_i)));

   // R7: the delay moves only together with a hit
   assert_delay_held_R7: assert property (@(posedge clk) disable iff (!rst_n)
      $past(rst_n) && !hit_vld_o |-> $stable(cur_dly_o));

   // R6: a sweep-done pulse comes with a hit and a reload of the start delay
   assert_wrap_reload_R6: assert property (@(posedge clk) disable iff (!rst_n)
      sweep_done_o |-> hit_vld_o && (cur_dly_o == $past(start_dly_i)));
endmodule

bind gate_sweep_seq gss_checker #(.DLY_W(DLY_W)) u_gss_checker (
   .clk          (clk),
   .rst_n        (rst_n),
   .det_i        (det_i),
   .start_dly_i  (start_dly_i),
   .win_end_i    (win_end_i),
   .gate_en_o    (gate_en_o),
   .hit_vld_o    (hit_vld_o),
   .hit_ts_o     (hit_ts_o),
   .cur_dly_o    (cur_dly_o),
   .sweep_done_o (sweep_done_o)
);

// File: tb/gate_sweep_seq_bench.sv
`timescale 1ns/1ps
module gate_sweep_seq_bench;
   localparam int DLY_W = 10;

   logic             clk = 1'b0;
   logic             rst_n = 1'b0;
   logic             sync_i = 1'b0;
   logic             det_i = 1'b0;
   logic [DLY_W-1:0] start_dly_i = 10'd3;
   logic [DLY_W-1:0] step_i = 10'd2;
   logic [DLY_W-1:0] win_end_i = 10'd10;
   logic             gate_en_o;
   logic             hit_vld_o;
   logic [DLY_W-1:0] hit_ts_o;
   logic [DLY_W-1:0] cur_dly_o;
   logic             sweep_done_o;

   int vectors = 0;
   int misses = 0;
   int exp_dly = 3;
   bit finished = 1'b0;

   always #5 clk = ~clk;

   gate_sweep_seq #(.DLY_W(DLY_W)) u_gate_sweep_seq (
      .clk (clk), .rst_n (rst_n), .sync_i (sync_i), .det_i (det_i),
      .start_dly_i (start_dly_i), .step_i (step_i), .win_end_i (win_end_i),
      .gate_en_o (gate_en_o), .hit_vld_o (hit_vld_o), .hit_ts_o (hit_ts_o),
      .cur_dly_o (cur_dly_o), .sweep_done_o (sweep_done_o)
   );

   task automatic chk(input string req, input int act, input int exp);
      vectors++;
      if (act != exp) begin
         misses++;
         $display("FAIL %s actual=%0d expected=%0d at %0t", req, act, exp, $time);
      end
   endtask

   task automatic do_reset(input int start);
      @(negedge clk);
      rst_n = 1'b0;
      start_dly_i = start[DLY_W-1:0];
      repeat (3) @(negedge clk);
      chk("R1 gate in reset", int'(gate_en_o), 0);
      rst_n = 1'b1;
      @(negedge clk);
      chk("R1 gate", int'(gate_en_o), 0);
      chk("R1 hit_vld", int'(hit_vld_o), 0);
      chk("R1 sweep_done", int'(sweep_done_o), 0);
      chk("R1 delay", int'(cur_dly_o), start);
      exp_dly = start;
   endtask

   // One run: detections in positions da and db, extra sync in position sx (-1 = none)
   task automatic run_gate(input string tag, input int da, input int db, input int sx);
      int d = exp_dly;
      int we = int'(win_end_i);
      int hit_t = -1;
      int nd;
      bit wrap = 1'b0;
      if (da >= d && da <= we) hit_t = da;
      if (hit_t < 0 && db >= d && db <= we) hit_t = db;
      nd = d;
      if (hit_t >= 0) begin
         nd = d + int'(step_i);
         if (nd > we) begin
            nd = int'(start_dly_i);
            wrap = 1'b1;
         end
      end
      @(negedge clk);
      sync_i = 1'b1;
      @(negedge clk);
      sync_i = 1'b0;
      for (int t = 0; t <= we + 2; t++) begin
         bit eg = (t >= d) && (t <= we) && (hit_t < 0 || t <= hit_t);
         chk({tag, " R2 gate"}, int'(gate_en_o), int'(eg));
         if (hit_t >= 0 && t == hit_t + 1) begin
            chk({tag, " R3 hit_vld"}, int'(hit_vld_o), 1);
            chk({tag, " R4 timestamp"}, int'(hit_ts_o), hit_t);
            chk({tag, " R6 sweep_done"}, int'(sweep_done_o), int'(wrap));
            chk({tag, " R5 delay"}, int'(cur_dly_o), nd);
         end else begin
            chk({tag, " R3 no hit"}, int'(hit_vld_o), 0);
            chk({tag, " R6 no done"}, int'(sweep_done_o), 0);
            chk({tag, " R7 delay"}, int'(cur_dly_o), (hit_t >= 0 && t > hit_t) ? nd : d);
         end
         det_i  = (t == da) || (t == db);
         sync_i = (t == sx);
         @(negedge clk);
      end
      det_i = 1'b0;
      sync_i = 1'b0;
      exp_dly = nd;
   endtask

   initial begin
      do_reset(3);
      run_gate("mid_gate", 5, -1, -1);       // R4 R5: ts 5, delay 3->5
      run_gate("no_det", -1, -1, -1);        // R7: delay stays 5
      run_gate("early_det", 2, 7, -1);       // R3: det 2 ignored, hit 7
      run_gate("double_det", 8, 9, -1);      // R3: hit 8, 9 ignored
      run_gate("last_pos", 10, -1, -1);      // R9 R6: ts 10, wrap to 3
      run_gate("sync_in_gate", -1, -1, 5);   // R8: resync ignored
      @(negedge clk);
      step_i = 10'd7;
      run_gate("land_on_end", 4, -1, -1);    // R6 boundary: 3+7=10, no wrap
      run_gate("wrap_from_end", 10, -1, -1); // R6: 10+7>10 wraps
      do_reset(0);
      step_i = 10'd2;
      run_gate("zero_delay", 0, -1, -1);     // R10: ts 0
      run_gate("sync_in_wait", -1, 1, 1);    // R8 R3: d=2, det 1 outside gate
      if (!finished) begin
         finished = 1'b1;
         $display("== %0d vectors applied, %0d miscompares ==", vectors, misses);
         $finish;
      end
   end

   initial begin
      #1_000_000;
      if (!finished) begin
         finished = 1'b1;
         misses++;
         vectors++;
         $display("FAIL watchdog expired actual=1 expected=0");
         $display("== %0d vectors applied, %0d miscompares ==", vectors, misses);
         $finish;
      end
   end
endmodule